// File: doc/BRIEF.md
# Configurable Auxiliary I/O Address Decoder

This block holds three small configuration registers reached through an index/data pair, and turns their contents into a programmable chip-select for an auxiliary I/O address range. A host first writes a register index with the index strobe, then reads or writes the selected register through the data port. Register access is possible only while the external configuration-mode input is high. The block does not handle entering or leaving configuration mode.

The first two registers hold a 7-bit compare value for address bits 10 down to 4 and a 2-bit decode mode. The mode sets how much of the 16-byte window selected by the compare value is claimed: nothing, a single byte at offset zero, the lower eight bytes, or all sixteen bytes. The decode strobe is combinational and is qualified by an external active-low chip select. The third register carries a 4-bit FIFO threshold, which is passed straight out, and a 2-bit infrared routing code. The routing code connects the active device's IR transmit and receive signals to a primary or a secondary pin pair, or releases both transmit pins.

The block has two resets. Power-on reset clears every register. A hardware reset returns only the IR routing code to its default.

Top module: `auxio_decoder`

## Requirements
- R1: Index writes (`cfg_wr_idx`) and data writes (`cfg_wr_dat`) take effect at the clock edge where they are sampled, and only while `cfg_mode` is 1. Otherwise they are ignored. While `cfg_mode` is 0, `cfg_rdata` is 00h. A data write that changes the decode settings changes `aux_sel` directly after that edge.
- R2: After power-on reset (`por_n` low), the index register and all three configuration registers read 00h, `aux_sel` is 0, `fifo_thresh` is 0 and IR routing is code 00.
- R3: The register at index 08h keeps bits [7:4] as compare bits A7..A4. Its bits [3:0] ignore writes and read as 0.
- R4: The register at index 09h keeps bits [2:0] as compare bits A10..A8 and bits [7:6] as the decode mode. Its bits [5:3] ignore writes and read as 0.
- R5: Decode mode 00 keeps `aux_sel` at 0 for every address.
- R6: Decode mode 01 asserts `aux_sel` only when `io_addr[3:0]` is 0000.
- R7: Decode mode 10 asserts `aux_sel` when `io_addr[3]` is 0, whatever `io_addr[2:0]` is.
- R8: Decode mode 11 asserts `aux_sel` for every value of `io_addr[3:0]`.
- R9: `aux_sel` is 1 only when `io_cs_n` is 0 and `io_addr[10:4]` equals the 7-bit compare value {reg09[2:0], reg08[7:4]}.
- R10: The register at index 0Ah keeps bits [3:0] as the FIFO threshold, driven on `fifo_thresh`, and bits [7:6] as the IR routing code. Its bits [5:4] ignore writes and read as 0.
- R11: Routing code 00 drives `dev_ir_tx` on `ir_tx_pri` and feeds `ir_rx_pri` to `dev_ir_rx`. Code 01 does the same with the secondary pair. Both transmit enables are 1, and the unselected transmit pin is driven 0.
- R12: Routing codes 10 and 11 set both transmit enables to 0 and both transmit pins to 0, and hold `dev_ir_rx` at 1.
- R13: A low level on `hw_rst_n` returns the routing code to 00. It leaves the index, the compare bits, the decode mode and the FIFO threshold unchanged.
- R14: While the index register holds a value other than 08h, 09h or 0Ah, a data read returns 00h and a data write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all registers |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous; clears the IR routing code only |
| cfg_mode | input | 1 | Configuration mode active |
| cfg_wr_idx | input | 1 | Write strobe for the index register |
| cfg_wr_dat | input | 1 | Write strobe for the indexed data register |
| cfg_wdata | input | 8 | Write data for index or data |
| cfg_rdata | output | 8 | Read data of the indexed register |
| io_addr | input | ADDR_W | I/O address being decoded |
| io_cs_n | input | 1 | External chip select, active low, qualifies the decode |
| aux_sel | output | 1 | Auxiliary range decode strobe, active high |
| fifo_thresh | output | 4 | Parallel-port FIFO threshold |
| dev_ir_tx | input | 1 | IR transmit data from the active device |
| dev_ir_rx | output | 1 | IR receive data to the active device |
| ir_rx_pri | input | 1 | Receive pin of the primary IR pair |
| ir_rx_sec | input | 1 | Receive pin of the secondary IR pair |
| ir_tx_pri | output | 1 | Transmit pin of the primary IR pair |
| ir_tx_pri_en | output | 1 | Output enable of the primary transmit pin |
| ir_tx_sec | output | 1 | Transmit pin of the secondary IR pair |
| ir_tx_sec_en | output | 1 | Output enable of the secondary transmit pin |

## Verification
The bench builds the block with its defaults: an 11-bit address and an 8-bit index. The 11-bit address lets every address be swept with both chip-select levels, for each of the four decode modes and for several compare values, so the byte, half-window and full-window boundaries are all hit. The 8-bit index lets every one of the 256 index values be written and read back, which covers every unimplemented index. IR routing is checked for all four codes against every combination of transmit and receive levels.

// File: rtl/auxio_pkg.sv
package auxio_pkg;

   localparam int unsigned REG_W = 8;   // configuration register width
   localparam int unsigned OFS_W = 4;   // byte offset bits inside the window
   localparam int unsigned CMP_W = 7;   // compared address bits above the offset

   typedef enum logic [1:0] {
      DEC_OFF  = 2'b00,
      DEC_BYTE = 2'b01,
      DEC_HALF = 2'b10,
      DEC_FULL = 2'b11
   } dec_mode_e;

   typedef enum logic [1:0] {
      IR_PRI = 2'b00,
      IR_SEC = 2'b01,
      IR_RSV = 2'b10,
      IR_OFF = 2'b11
   } ir_route_e;

   typedef struct packed {
      logic [CMP_W-1:0] cmp;
      dec_mode_e        mode;
      logic [3:0]       fifo_thr;
      ir_route_e        route;
   } cfg_s;

endpackage

// File: rtl/auxio_cfg_regs.sv
module auxio_cfg_regs
   import auxio_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter logic [7:0]  IDX_MID = 8'h08,
   parameter logic [7:0]  IDX_UP  = 8'h09,
   parameter logic [7:0]  IDX_AUX = 8'h0A
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             hw_rst_n,
   input  logic             cfg_mode,
   input  logic             wr_idx,
   input  logic             wr_dat,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output cfg_s             cfg
);

   localparam logic [IDX_W-1:0] K_MID = IDX_W'(IDX_MID);
   localparam logic [IDX_W-1:0] K_UP  = IDX_W'(IDX_UP);
   localparam logic [IDX_W-1:0] K_AUX = IDX_W'(IDX_AUX);

   if (IDX_W < 4 || IDX_W > REG_W) begin : g_bad_idx_w
      $error("auxio_cfg_regs: IDX_W must lie in 4..8");
   end
   if (K_MID == K_UP || K_MID == K_AUX || K_UP == K_AUX) begin : g_bad_idx_val
      $error("auxio_cfg_regs: register indices must be distinct");
   end

   logic [IDX_W-1:0] idx_q;
   logic [3:0]       mid_q;
   logic [2:0]       hi_q;
   dec_mode_e        mode_q;
   logic [3:0]       thr_q;
   ir_route_e        route_q;

   logic hit_mid, hit_up, hit_aux, hit_any, dat_we;

   assign hit_mid = (idx_q == K_MID);
   assign hit_up  = (idx_q == K_UP);
   assign hit_aux = (idx_q == K_AUX);
   assign hit_any = hit_mid | hit_up | hit_aux;
   assign dat_we  = cfg_mode & wr_dat;

   // index register
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         idx_q <= '0;
      end else if (cfg_mode && wr_idx) begin
         idx_q <= wdata[IDX_W-1:0];
      end
   end

   // fields cleared by power-on reset only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mid_q  <= '0;
         hi_q   <= '0;
         mode_q <= DEC_OFF;
         thr_q  <= '0;
      end else if (dat_we) begin
         if (hit_mid) begin
            mid_q <= wdata[7:4];
         end
         if (hit_up) begin
            hi_q   <= wdata[2:0];
            mode_q <= dec_mode_e'(wdata[7:6]);
         end
         if (hit_aux) begin
            thr_q <= wdata[3:0];
         end
      end
   end

   // routing code: also returns to default on a hardware reset
   always_ff @(posedge clk or negedge por_n or negedge hw_rst_n) begin
      if (!por_n || !hw_rst_n) begin
         route_q <= IR_PRI;
      end else if (dat_we && hit_aux) begin
         route_q <= ir_route_e'(wdata[7:6]);
      end
   end

   // read path: reserved bits and unknown indices return zero
   always_comb begin
      rdata = '0;
      if (cfg_mode) begin
         if (hit_mid) begin
            rdata = {mid_q, 4'b0000};
         end else if (hit_up) begin
            rdata = {mode_q, 3'b000, hi_q};
         end else if (hit_aux) begin
            rdata = {route_q, 2'b00, thr_q};
         end
      end
   end

   assign cfg.cmp      = {hi_q, mid_q};
   assign cfg.mode     = mode_q;
   assign cfg.fifo_thr = thr_q;
   assign cfg.route    = route_q;

   assert_hold_outside_cfg_R1: assert property (@(posedge clk) disable iff (!por_n)
      !cfg_mode |=> $stable({idx_q, mid_q, hi_q, mode_q, thr_q}));

   assert_unimpl_write_R14: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_mode && wr_dat && !wr_idx && !hit_any) |=> $stable({mid_q, hi_q, mode_q, thr_q}));

   assert_hw_reset_route_R13: assert property (@(posedge clk) disable iff (!por_n)
      !hw_rst_n |-> (route_q == IR_PRI));

   assert_reserved_read_R4: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_mode && hit_up) |-> (rdata[5:3] == 3'b000));

endmodule

// File: rtl/auxio_addr_match.sv
module auxio_addr_match
   import auxio_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cs_n,
   input  logic [CMP_W-1:0]  cmp,
   input  dec_mode_e         mode,
   output logic              sel
);

   localparam int unsigned CMP_LSB = OFS_W;
   localparam int unsigned CMP_MSB = OFS_W + CMP_W - 1;

   if (ADDR_W < CMP_MSB + 1) begin : g_bad_addr_w
      $error("auxio_addr_match: ADDR_W too small for the compare field");
   end

   logic             win_hit;
   logic             ofs_hit;
   logic [OFS_W-1:0] ofs;

   assign ofs     = addr[OFS_W-1:0];
   assign win_hit = (addr[CMP_MSB:CMP_LSB] == cmp);

   always_comb begin
      unique case (mode)
         DEC_OFF:  ofs_hit = 1'b0;
         DEC_BYTE: ofs_hit = (ofs == '0);
         DEC_HALF: ofs_hit = ~ofs[OFS_W-1];
         DEC_FULL: ofs_hit = 1'b1;
         default:  ofs_hit = 1'b0;
      endcase
   end

   assign sel = ~cs_n & win_hit & ofs_hit;

   assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!por_n)
      (mode == DEC_OFF) |-> !sel);

   assert_cs_qualify_R9: assert property (@(posedge clk) disable iff (!por_n)
      sel |-> (!cs_n && addr[CMP_MSB:CMP_LSB] == cmp));

   assert_byte_only_R6: assert property (@(posedge clk) disable iff (!por_n)
      (sel && mode == DEC_BYTE) |-> (addr[OFS_W-1:0] == '0));

   assert_lower_half_R7: assert property (@(posedge clk) disable iff (!por_n)
      (sel && mode == DEC_HALF) |-> !addr[OFS_W-1]);

endmodule

// File: rtl/auxio_ir_route.sv
module auxio_ir_route
   import auxio_pkg::*;
#(
   parameter logic TX_IDLE = 1'b0,
   parameter logic RX_IDLE = 1'b1
) (
   input  logic      clk,
   input  logic      por_n,
   input  ir_route_e route,
   input  logic      dev_tx,
   output logic      dev_rx,
   input  logic      rx_pri,
   input  logic      rx_sec,
   output logic      tx_pri,
   output logic      tx_pri_en,
   output logic      tx_sec,
   output logic      tx_sec_en
);

   localparam int unsigned NPAIR = 2;

   logic [NPAIR-1:0] rx_pin;
   logic [NPAIR-1:0] tx_pin;
   logic [NPAIR-1:0] tx_en;
   logic             live;

   assign live   = ~route[1];          // codes 10 and 11 release both pairs
   assign rx_pin = {rx_sec, rx_pri};

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic chosen;
      assign chosen    = live && (route[0] == p[0]);
      assign tx_en[p]  = live;
      assign tx_pin[p] = chosen ? dev_tx : TX_IDLE;
   end

   assign dev_rx    = live ? rx_pin[route[0]] : RX_IDLE;
   assign tx_pri    = tx_pin[0];
   assign tx_sec    = tx_pin[1];
   assign tx_pri_en = tx_en[0];
   assign tx_sec_en = tx_en[1];

   assert_released_R12: assert property (@(posedge clk) disable iff (!por_n)
      route[1] |-> (!tx_pri_en && !tx_sec_en && dev_rx == RX_IDLE));

   assert_primary_path_R11: assert property (@(posedge clk) disable iff (!por_n)
      (route == IR_PRI) |-> (tx_pri == dev_tx && dev_rx == rx_pri && tx_sec == TX_IDLE));

   assert_secondary_path_R11: assert property (@(posedge clk) disable iff (!por_n)
      (route == IR_SEC) |-> (tx_sec == dev_tx && dev_rx == rx_sec && tx_pri == TX_IDLE));

endmodule

// File: rtl/auxio_decoder.sv
module auxio_decoder
   import auxio_pkg::*;
#(
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned IDX_W   = 8,
   parameter logic [7:0]  IDX_MID = 8'h08,
   parameter logic [7:0]  IDX_UP  = 8'h09,
   parameter logic [7:0]  IDX_AUX = 8'h0A
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hw_rst_n,
   input  logic              cfg_mode,
   input  logic              cfg_wr_idx,
   input  logic              cfg_wr_dat,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_cs_n,
   output logic              aux_sel,
   output logic [3:0]        fifo_thresh,
   input  logic              dev_ir_tx,
   output logic              dev_ir_rx,
   input  logic              ir_rx_pri,
   input  logic              ir_rx_sec,
   output logic              ir_tx_pri,
   output logic              ir_tx_pri_en,
   output logic              ir_tx_sec,
   output logic              ir_tx_sec_en
);

   cfg_s cfg;

   auxio_cfg_regs #(
      .IDX_W  (IDX_W),
      .IDX_MID(IDX_MID),
      .IDX_UP (IDX_UP),
      .IDX_AUX(IDX_AUX)
   ) u_regs (
      .clk     (clk),
      .por_n   (por_n),
      .hw_rst_n(hw_rst_n),
      .cfg_mode(cfg_mode),
      .wr_idx  (cfg_wr_idx),
      .wr_dat  (cfg_wr_dat),
      .wdata   (cfg_wdata),
      .rdata   (cfg_rdata),
      .cfg     (cfg)
   );

   auxio_addr_match #(
      .ADDR_W(ADDR_W)
   ) u_match (
      .clk  (clk),
      .por_n(por_n),
      .addr (io_addr),
      .cs_n (io_cs_n),
      .cmp  (cfg.cmp),
      .mode (cfg.mode),
      .sel  (aux_sel)
   );

   auxio_ir_route u_ir (
      .clk      (clk),
      .por_n    (por_n),
      .route    (cfg.route),
      .dev_tx   (dev_ir_tx),
      .dev_rx   (dev_ir_rx),
      .rx_pri   (ir_rx_pri),
      .rx_sec   (ir_rx_sec),
      .tx_pri   (ir_tx_pri),
      .tx_pri_en(ir_tx_pri_en),
      .tx_sec   (ir_tx_sec),
      .tx_sec_en(ir_tx_sec_en)
   );

   assign fifo_thresh = cfg.fifo_thr;

   assert_idle_read_R1: assert property (@(posedge clk) disable iff (!por_n)
      !cfg_mode |-> (cfg_rdata == 8'h00));

endmodule

// File: tb/tb_auxio_decoder.sv
module tb_auxio_decoder;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        hw_rst_n = 1'b1;
   logic        cfg_mode = 1'b0;
   logic        cfg_wr_idx = 1'b0;
   logic        cfg_wr_dat = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic [10:0] io_addr = '0;
   logic        io_cs_n = 1'b1;
   logic        aux_sel;
   logic [3:0]  fifo_thresh;
   logic        dev_ir_tx = 1'b0;
   logic        dev_ir_rx;
   logic        ir_rx_pri = 1'b0;
   logic        ir_rx_sec = 1'b0;
   logic        ir_tx_pri, ir_tx_pri_en, ir_tx_sec, ir_tx_sec_en;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   auxio_decoder dut (
      .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .cfg_mode(cfg_mode),
      .cfg_wr_idx(cfg_wr_idx), .cfg_wr_dat(cfg_wr_dat), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .io_addr(io_addr), .io_cs_n(io_cs_n), .aux_sel(aux_sel),
      .fifo_thresh(fifo_thresh), .dev_ir_tx(dev_ir_tx), .dev_ir_rx(dev_ir_rx),
      .ir_rx_pri(ir_rx_pri), .ir_rx_sec(ir_rx_sec), .ir_tx_pri(ir_tx_pri),
      .ir_tx_pri_en(ir_tx_pri_en), .ir_tx_sec(ir_tx_sec), .ir_tx_sec_en(ir_tx_sec_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_idx(input logic [7:0] v);
      @(negedge clk);
      cfg_wr_idx = 1'b1;
      cfg_wdata  = v;
      @(negedge clk);
      cfg_wr_idx = 1'b0;
   endtask

   task automatic put_dat(input logic [7:0] v);
      @(negedge clk);
      cfg_wr_dat = 1'b1;
      cfg_wdata  = v;
      @(negedge clk);
      cfg_wr_dat = 1'b0;
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
      put_idx(idx);
      put_dat(v);
   endtask

   task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
      put_idx(idx);
      #1 v = cfg_rdata;
   endtask

   function automatic logic exp_sel(input int a, input int cs, input int cmp, input int m);
      if (cs != 0) return 1'b0;
      if (((a >> 4) & 'h7F) != cmp) return 1'b0;
      case (m)
         0:       return 1'b0;
         1:       return (a & 15) == 0;
         2:       return ((a >> 3) & 1) == 0;
         default: return 1'b1;
      endcase
   endfunction

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      string      tag;

      // R2: power-on reset state
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      cfg_mode = 1'b1;
      #1;
      check("R2 index reset reads reg 00h -> 0", {24'h0, cfg_rdata}, 32'h0);
      check("R2 aux_sel after reset", {31'h0, aux_sel}, 32'h0);
      check("R2 fifo_thresh after reset", {28'h0, fifo_thresh}, 32'h0);
      check("R2 primary tx enable after reset", {31'h0, ir_tx_pri_en}, 32'h1);
      get_reg(8'h08, rv); check("R2 reg08 reset", {24'h0, rv}, 32'h0);
      get_reg(8'h09, rv); check("R2 reg09 reset", {24'h0, rv}, 32'h0);
      get_reg(8'h0A, rv); check("R2 reg0A reset", {24'h0, rv}, 32'h0);

      // R3 R4 R10: write every value, read back through reserved-bit masks
      for (int v = 0; v < 256; v++) begin
         set_reg(8'h08, 8'(v)); #1;
         check("R3 reg08 readback", {24'h0, cfg_rdata}, v & 'hF0);
         set_reg(8'h09, 8'(v)); #1;
         check("R4 reg09 readback", {24'h0, cfg_rdata}, v & 'hC7);
         set_reg(8'h0A, 8'(v)); #1;
         check("R10 reg0A readback", {24'h0, cfg_rdata}, v & 'hCF);
         check("R10 fifo_thresh output", {28'h0, fifo_thresh}, v & 'hF);
      end

      // R14: unimplemented indices
      set_reg(8'h08, 8'h50);
      set_reg(8'h09, 8'h43);
      set_reg(8'h0A, 8'h07);
      for (int i = 0; i < 256; i++) begin
         if (i < 8 || i > 10) begin
            set_reg(8'(i), 8'hFF); #1;
            check("R14 unimplemented index reads 00h", {24'h0, cfg_rdata}, 32'h0);
         end
      end
      get_reg(8'h08, rv); check("R14 reg08 untouched", {24'h0, rv}, 32'h50);
      get_reg(8'h09, rv); check("R14 reg09 untouched", {24'h0, rv}, 32'h43);
      get_reg(8'h0A, rv); check("R14 reg0A untouched", {24'h0, rv}, 32'h07);

      // R1: accesses outside configuration mode
      put_idx(8'h08);
      @(negedge clk);
      cfg_mode = 1'b0;
      #1 check("R1 read outside cfg mode", {24'h0, cfg_rdata}, 32'h0);
      put_dat(8'hA0);
      put_idx(8'h09);
      @(negedge clk);
      cfg_mode = 1'b1;
      #1 check("R1 writes outside cfg mode ignored", {24'h0, cfg_rdata}, 32'h50);

      // R1: decode reacts right after the write edge
      set_reg(8'h08, 8'h00);
      set_reg(8'h09, 8'h00);
      io_addr = 11'h00F;
      io_cs_n = 1'b0;
      @(negedge clk);
      cfg_wr_dat = 1'b1;
      cfg_wdata  = 8'hC0;
      #2 check("R1 aux_sel before write edge", {31'h0, aux_sel}, 32'h0);
      @(posedge clk);
      #1 check("R1 aux_sel after write edge", {31'h0, aux_sel}, 32'h1);
      @(negedge clk);
      cfg_wr_dat = 1'b0;

      // R5 R6 R7 R8 R9: exhaustive address sweep per mode and compare value
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 3; c++) begin
            int cmp;
            cmp = (c == 0) ? 'h00 : (c == 1) ? 'h5A : 'h7F;
            set_reg(8'h08, 8'(((cmp & 15) << 4) | 'hF));
            set_reg(8'h09, 8'((m << 6) | 'h38 | (cmp >> 4)));
            case (m)
               0:       tag = "R5 mode off decode";
               1:       tag = "R6 single byte decode";
               2:       tag = "R7 lower half decode";
               default: tag = "R8 full window decode";
            endcase
            for (int a = 0; a < 2048; a++) begin
               for (int cs = 0; cs < 2; cs++) begin
                  io_addr = 11'(a);
                  io_cs_n = cs[0];
                  #1;
                  if (cs != 0) check("R9 cs_n high blocks decode", {31'h0, aux_sel}, 32'h0);
                  else check(tag, {31'h0, aux_sel}, {31'h0, exp_sel(a, cs, cmp, m)});
               end
            end
         end
      end
      io_cs_n = 1'b1;

      // R11 R12: IR routing for all codes and signal levels
      for (int code = 0; code < 4; code++) begin
         set_reg(8'h0A, 8'(code << 6));
         for (int p = 0; p < 8; p++) begin
            logic en, etp, ets, erx;
            dev_ir_tx = p[0];
            ir_rx_pri = p[1];
            ir_rx_sec = p[2];
            #1;
            en  = (code < 2);
            etp = (code == 0) ? p[0] : 1'b0;
            ets = (code == 1) ? p[0] : 1'b0;
            erx = (code == 0) ? p[1] : (code == 1) ? p[2] : 1'b1;
            if (code < 2) begin
               check("R11 primary enable", {31'h0, ir_tx_pri_en}, {31'h0, en});
               check("R11 secondary enable", {31'h0, ir_tx_sec_en}, {31'h0, en});
               check("R11 primary tx", {31'h0, ir_tx_pri}, {31'h0, etp});
               check("R11 secondary tx", {31'h0, ir_tx_sec}, {31'h0, ets});
               check("R11 device rx", {31'h0, dev_ir_rx}, {31'h0, erx});
            end else begin
               check("R12 primary enable off", {31'h0, ir_tx_pri_en}, {31'h0, en});
               check("R12 secondary enable off", {31'h0, ir_tx_sec_en}, {31'h0, en});
               check("R12 primary tx", {31'h0, ir_tx_pri}, {31'h0, etp});
               check("R12 secondary tx", {31'h0, ir_tx_sec}, {31'h0, ets});
               check("R12 device rx idle", {31'h0, dev_ir_rx}, {31'h0, erx});
            end
         end
      end

      // R13: hardware reset touches routing only
      set_reg(8'h08, 8'h30);
      set_reg(8'h09, 8'h41);
      set_reg(8'h0A, 8'h4B);
      @(negedge clk);
      hw_rst_n = 1'b0;
      #2 hw_rst_n = 1'b1;
      #1 check("R13 routing cleared, threshold kept", {24'h0, cfg_rdata}, 32'h0B);
      check("R13 primary tx enable restored", {31'h0, ir_tx_pri_en}, 32'h1);
      get_reg(8'h08, rv); check("R13 reg08 kept", {24'h0, rv}, 32'h30);
      get_reg(8'h09, rv); check("R13 reg09 kept", {24'h0, rv}, 32'h41);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule